// File: doc/BRIEF.md
# Dual-Width Logic, Arithmetic and Shift Channel

This block is a single execution lane of a wide-issue core. It takes two 64-bit source operands, the current 64-bit contents of the destination register, an 8-bit opcode and a valid strobe. One clock later it returns the result, together with two flags. One flag reports an opcode the lane does not implement. The other reports the opcode reserved for raising an exception. Operand fetch and register writeback belong to the surrounding pipeline.

Opcodes are grouped in pairs. An even code selects the 32-bit single form of an operation and the next odd code selects the 64-bit double form. A single-form operation works on the low 32 bits of both sources. It writes only the low half of the result; the upper half is the upper half of the old destination, passed through unchanged. This lets a 32-bit operation update part of a 64-bit register without a separate merge step.

Top module: `alu_chan`

## Requirements
- R1: While rst_ni is low, valid_o, result_o, undef_o and excp_o are all zero, whatever the inputs are.
- R2: Outputs are registered. A cycle with valid_i high produces valid_o high on the next cycle. A cycle with valid_i low produces valid_o, result_o, undef_o and excp_o all zero on the next cycle.
- R3: Bitwise codes: 0x00/0x01 AND, 0x04/0x05 OR, 0x08/0x09 XOR of src1 and src2. Opcode bit 0 set selects the 64-bit form and clear selects the 32-bit form; this holds for all pairs.
- R4: Codes 0x02/0x03, 0x06/0x07 and 0x0a/0x0b return the bitwise complement of AND, OR and XOR respectively.
- R5: Codes 0x10/0x11 add and 0x12/0x13 subtract (src1 minus src2), wrapping modulo the operation width.
- R6: Codes 0x14/0x15 rotate src1 left and 0x16/0x17 rotate src1 right by the amount given in src2.
- R7: Codes 0x18/0x19 shift src1 left logically, 0x1a/0x1b shift it right logically, and 0x1c/0x1d shift it right arithmetically, by the amount given in src2.
- R8: The shift or rotate amount is src2 bits [4:0] for single forms and src2 bits [5:0] for double forms; all higher bits of src2 are ignored.
- R9: A single-form result has bits [63:32] equal to dst_old_i[63:32] and bits [31:0] equal to the 32-bit operation on src1[31:0] and src2[31:0].
- R10: A double-form result is independent of dst_old_i.
- R11: Opcode 0x40 sets excp_o, clears undef_o and returns a zero result.
- R12: Any opcode not listed in R3 to R7 and not 0x40 (for example 0x0c to 0x0f, 0x1e, 0x1f, 0x41, 0xff) sets undef_o, clears excp_o and returns a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 8 | Operation code |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand; also the shift or rotate amount |
| dst_old_i | input | 64 | Current destination value; its upper half is used by single forms |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result |
| undef_o | output | 1 | Opcode not implemented by this lane |
| excp_o | output | 1 | Exception opcode seen |

## Verification
In a single-form shift or rotate, two behaviours apply at once: the amount is truncated modulo 32, and the upper half is taken from the old destination. The bench provokes this with amounts of 32 and above, using distinct bit patterns in each half of dst_old_i and src2. A wrong amount width or a lost pass-through then shows up in different bit ranges of the same result word. The bench also sends back-to-back operations, mixing 32-bit and 64-bit forms with exception and undefined codes in adjacent cycles. A behavioural reference model predicts every output on every clock, including idle cycles, and each mismatch is reported with the requirement it belongs to.

// File: rtl/alu_chan_pkg.sv
package alu_chan_pkg;
  localparam int unsigned OPC_W = 8;

  // opcode[7:1] pair codes; opcode[0] selects double width
  localparam logic [OPC_W-2:0] PAIR_AND  = 7'h00;
  localparam logic [OPC_W-2:0] PAIR_ANDN = 7'h01;
  localparam logic [OPC_W-2:0] PAIR_OR   = 7'h02;
  localparam logic [OPC_W-2:0] PAIR_ORN  = 7'h03;
  localparam logic [OPC_W-2:0] PAIR_XOR  = 7'h04;
  localparam logic [OPC_W-2:0] PAIR_XORN = 7'h05;
  localparam logic [OPC_W-2:0] PAIR_ADD  = 7'h08;
  localparam logic [OPC_W-2:0] PAIR_SUB  = 7'h09;
  localparam logic [OPC_W-2:0] PAIR_ROL  = 7'h0a;
  localparam logic [OPC_W-2:0] PAIR_ROR  = 7'h0b;
  localparam logic [OPC_W-2:0] PAIR_SHL  = 7'h0c;
  localparam logic [OPC_W-2:0] PAIR_SHR  = 7'h0d;
  localparam logic [OPC_W-2:0] PAIR_SAR  = 7'h0e;
  localparam logic [OPC_W-1:0] EXCP_CODE = 8'h40;

  typedef enum logic [3:0] {
    OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SUB,
    OP_ROL, OP_ROR, OP_SHL, OP_SHR, OP_SAR
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    inv;
    logic    dbl;
    logic    undef;
    logic    excp;
  } alu_dec_t;
endpackage

// File: rtl/alu_chan_decode.sv
module alu_chan_decode
  import alu_chan_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output alu_dec_t         dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.op    = OP_AND;
    dec_o.dbl   = opcode_i[0];
    if (opcode_i == EXCP_CODE) begin
      dec_o.excp = 1'b1;
    end else begin
      unique case (opcode_i[OPC_W-1:1])
        PAIR_AND:  dec_o.op = OP_AND;
        PAIR_ANDN: begin dec_o.op = OP_AND; dec_o.inv = 1'b1; end
        PAIR_OR:   dec_o.op = OP_OR;
        PAIR_ORN:  begin dec_o.op = OP_OR;  dec_o.inv = 1'b1; end
        PAIR_XOR:  dec_o.op = OP_XOR;
        PAIR_XORN: begin dec_o.op = OP_XOR; dec_o.inv = 1'b1; end
        PAIR_ADD:  dec_o.op = OP_ADD;
        PAIR_SUB:  dec_o.op = OP_SUB;
        PAIR_ROL:  dec_o.op = OP_ROL;
        PAIR_ROR:  dec_o.op = OP_ROR;
        PAIR_SHL:  dec_o.op = OP_SHL;
        PAIR_SHR:  dec_o.op = OP_SHR;
        PAIR_SAR:  dec_o.op = OP_SAR;
        default:   dec_o.undef = 1'b1;
      endcase
    end
  end

  always_comb begin
    assert_dec_flags_excl_R12: assert (!(dec_o.undef && dec_o.excp));
  end
endmodule

// File: rtl/alu_chan_shifter.sv
module alu_chan_shifter
  import alu_chan_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  alu_op_e               op_i,
  input  logic [W-1:0]          a_i,
  input  logic [$clog2(W)-1:0]  amt_i,
  output logic [W-1:0]          y_o
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] dup, dup_l, dup_r;
  assign dup   = {a_i, a_i};
  assign dup_l = dup << amt_i;
  assign dup_r = dup >> amt_i;

  always_comb begin
    unique case (op_i)
      OP_ROL:  y_o = dup_l[DW-1:W];
      OP_ROR:  y_o = dup_r[W-1:0];
      OP_SHL:  y_o = a_i << amt_i;
      OP_SHR:  y_o = a_i >> amt_i;
      OP_SAR:  y_o = W'($signed(a_i) >>> amt_i);
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_chan_lane.sv
module alu_chan_lane
  import alu_chan_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  alu_op_e      op_i,
  input  logic         inv_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned AMT_W = $clog2(W);

  logic [W-1:0] sh_y, base;

  alu_chan_shifter #(.W(W)) u_shift (
    .op_i  (op_i),
    .a_i   (a_i),
    .amt_i (b_i[AMT_W-1:0]),
    .y_o   (sh_y)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  base = a_i & b_i;
      OP_OR:   base = a_i | b_i;
      OP_XOR:  base = a_i ^ b_i;
      OP_ADD:  base = a_i + b_i;
      OP_SUB:  base = a_i - b_i;
      default: base = sh_y;
    endcase
  end

  assign y_o = inv_i ? ~base : base;
endmodule

// File: rtl/alu_chan.sv
module alu_chan
  import alu_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dst_old_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              undef_o,
  output logic              excp_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  alu_dec_t          dec;
  logic [HALF_W-1:0] y_s;
  logic [DATA_W-1:0] y_d, res_d;
  logic              dst_lo_unused;

  assign dst_lo_unused = ^dst_old_i[HALF_W-1:0];

  alu_chan_decode u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  alu_chan_lane #(.W(HALF_W)) u_lane_s (
    .op_i  (dec.op),
    .inv_i (dec.inv),
    .a_i   (src1_i[HALF_W-1:0]),
    .b_i   (src2_i[HALF_W-1:0]),
    .y_o   (y_s)
  );

  alu_chan_lane #(.W(DATA_W)) u_lane_d (
    .op_i  (dec.op),
    .inv_i (dec.inv),
    .a_i   (src1_i),
    .b_i   (src2_i),
    .y_o   (y_d)
  );

  always_comb begin
    if (dec.undef || dec.excp) res_d = '0;
    else if (dec.dbl)          res_d = y_d;
    else                       res_d = {dst_old_i[DATA_W-1:HALF_W], y_s};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      undef_o  <= 1'b0;
      excp_o   <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      result_o <= valid_i ? res_d : '0;
      undef_o  <= valid_i & dec.undef;
      excp_o   <= valid_i & dec.excp;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && result_o == '0 && !undef_o && !excp_o));
  assert_excp_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == EXCP_CODE) |=> (excp_o && !undef_o && result_o == '0));
  assert_undef_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == '0 && !excp_o));
  assert_flags_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, excp_o}));
  assert_upper_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !opcode_i[0] && !dec.undef && !dec.excp)
      |=> result_o[DATA_W-1:HALF_W] == $past(dst_old_i[DATA_W-1:HALF_W]));
endmodule

// File: tb/alu_chan_tb.sv
module alu_chan_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [63:0] src1_i = '0, src2_i = '0, dst_old_i = '0;
  logic        valid_o, undef_o, excp_o;
  logic [63:0] result_o;

  int  n_chk = 0, n_bad = 0, cyc = 0;
  bit  done = 0;

  logic        e_v = 0, e_u = 0, e_x = 0;
  logic [63:0] e_r = '0;
  string       e_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .src1_i(src1_i), .src2_i(src2_i), .dst_old_i(dst_old_i),
    .valid_o(valid_o), .result_o(result_o), .undef_o(undef_o), .excp_o(excp_o)
  );

  function automatic logic [63:0] ref64(input logic [6:0] p, input logic [63:0] a, b);
    logic [63:0] r;
    int s;
    s = int'(b[5:0]);
    r = '0;
    case (p)
      7'h00: r = a & b;
      7'h01: r = ~(a & b);
      7'h02: r = a | b;
      7'h03: r = ~(a | b);
      7'h04: r = a ^ b;
      7'h05: r = ~(a ^ b);
      7'h08: r = a + b;
      7'h09: r = a - b;
      7'h0a: begin r = a; for (int i = 0; i < s; i++) r = {r[62:0], r[63]}; end
      7'h0b: begin r = a; for (int i = 0; i < s; i++) r = {r[0], r[63:1]}; end
      7'h0c: begin r = a; for (int i = 0; i < s; i++) r = {r[62:0], 1'b0}; end
      7'h0d: begin r = a; for (int i = 0; i < s; i++) r = {1'b0, r[63:1]}; end
      7'h0e: begin r = a; for (int i = 0; i < s; i++) r = {r[63], r[63:1]}; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] ref32(input logic [6:0] p, input logic [31:0] a, b);
    logic [31:0] r;
    int s;
    s = int'(b[4:0]);
    r = '0;
    case (p)
      7'h00: r = a & b;
      7'h01: r = ~(a & b);
      7'h02: r = a | b;
      7'h03: r = ~(a | b);
      7'h04: r = a ^ b;
      7'h05: r = ~(a ^ b);
      7'h08: r = a + b;
      7'h09: r = a - b;
      7'h0a: begin r = a; for (int i = 0; i < s; i++) r = {r[30:0], r[31]}; end
      7'h0b: begin r = a; for (int i = 0; i < s; i++) r = {r[0], r[31:1]}; end
      7'h0c: begin r = a; for (int i = 0; i < s; i++) r = {r[30:0], 1'b0}; end
      7'h0d: begin r = a; for (int i = 0; i < s; i++) r = {1'b0, r[31:1]}; end
      7'h0e: begin r = a; for (int i = 0; i < s; i++) r = {r[31], r[31:1]}; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic bit known(input logic [7:0] c);
    return (c <= 8'h0b) || (c >= 8'h10 && c <= 8'h1d);
  endfunction

  function automatic string tag_of(input logic [7:0] c, input logic [63:0] b);
    string t;
    if (c == 8'h40) return "R11";
    if (!known(c)) return "R12";
    if (c <= 8'h0b) t = (c[1] ? "R4" : "R3");
    else if (c <= 8'h13) t = "R5";
    else if (c <= 8'h17) t = "R6";
    else t = "R7";
    if (c >= 8'h14 && (c[0] ? |b[63:6] : |b[63:5])) t = {t, "/R8"};
    t = {t, c[0] ? "/R10" : "/R9"};
    return t;
  endfunction

  task automatic check_now();
    n_chk++;
    if (valid_o !== e_v || result_o !== e_r || undef_o !== e_u || excp_o !== e_x) begin
      n_bad++;
      $display("FAIL %s: got v=%0b r=%h u=%0b x=%0b exp v=%0b r=%h u=%0b x=%0b",
               e_tag, valid_o, result_o, undef_o, excp_o, e_v, e_r, e_u, e_x);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] c, input logic [63:0] a, b, d);
    @(negedge clk);
    check_now();
    valid_i = v; opcode_i = c; src1_i = a; src2_i = b; dst_old_i = d;
    e_v = v; e_u = 0; e_x = 0; e_r = '0;
    if (!v) e_tag = "R2";
    else begin
      e_tag = tag_of(c, b);
      if (c == 8'h40) e_x = 1;
      else if (!known(c)) e_u = 1;
      else if (c[0]) e_r = ref64(c[7:1], a, b);
      else e_r = {d[63:32], ref32(c[7:1], a[31:0], b[31:0])};
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: got cycle=%0d exp below 100000", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] pa, pb, pd;
    // R1: reset holds outputs at zero despite active inputs
    valid_i = 1; opcode_i = 8'h41; src1_i = '1; src2_i = '1; dst_old_i = '1;
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (valid_o !== 0 || result_o !== '0 || undef_o !== 0 || excp_o !== 0) begin
        n_bad++;
        $display("FAIL R1: got v=%0b r=%h u=%0b x=%0b exp all zero",
                 valid_o, result_o, undef_o, excp_o);
      end
    end
    valid_i = 0;
    @(negedge clk);
    rst_n = 1;
    e_v = 0; e_r = '0; e_u = 0; e_x = 0; e_tag = "R2";

    pa = 64'hF0F0_1234_8765_A5C3;
    pb = 64'h0FF0_FFFF_3C3C_0F0F;
    pd = 64'hDEAD_BEEF_CAFE_F00D;
    // every code of the low range, plus exception and undefined neighbours
    for (int c = 0; c < 32; c++) step(1, 8'(c), pa, pb, pd);
    step(1, 8'h40, pa, pb, pd);     // R11
    step(1, 8'h41, pa, pb, pd);     // R12
    step(1, 8'hff, pa, pb, pd);     // R12
    step(0, 8'h11, pa, pb, pd);     // R2 idle
    // R5 wrap
    step(1, 8'h10, 64'h1111_1111_FFFF_FFFF, 64'h2, 64'hAAAA_5555_0000_0000);
    step(1, 8'h11, '1, 64'h1, pd);
    step(1, 8'h12, 64'h0, 64'h1, pd);
    step(1, 8'h13, 64'h0, 64'h1, pd);
    // R8 with R9: single forms with amounts >= 32, double with amounts >= 64
    step(1, 8'h18, pa, 64'hFFFF_FFFF_0000_0025, pd);
    step(1, 8'h14, pa, 64'h0000_0001_0000_0047, pd);
    step(1, 8'h1c, 64'h0000_0000_8000_0010, 64'h20, pd);
    step(1, 8'h1c, 64'h0000_0000_8000_0010, 64'h3f, pd);
    step(1, 8'h1d, 64'h8000_0000_0000_0010, 64'hC6, pd);
    step(1, 8'h17, pa, 64'h7F, pd);
    step(1, 8'h15, pa, 64'h40, pd);
    // R10: same double op, different old destination
    step(1, 8'h09, pa, pb, 64'h0);
    step(1, 8'h09, pa, pb, '1);
    step(1, 8'h40, pa, pb, pd);
    step(1, 8'h0e, pa, pb, pd);
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] c;
      int k;
      k = int'($urandom % 29);
      if ($urandom % 8 == 0) c = 8'($urandom);
      else if (k < 12) c = 8'(k);
      else if (k < 26) c = 8'(k + 4);
      else c = 8'h40;
      step(($urandom % 5) != 0, c, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom});
    end
    step(0, 8'h00, '0, '0, '0);
    step(0, 8'h00, '0, '0, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule